// File: doc/BRIEF.md
# Unaligned load-right merge unit

This unit is a load-pipeline slice that executes the right-hand half of an unaligned word load. It takes the instruction word, the 64-bit base register value and the current 64-bit value of the destination register. It forms the effective address, sends one doubleword-aligned read to a synchronous memory port, and splices the low-order 1 to 4 bytes of the addressed word into the bottom of the destination. The bytes of the destination above them are kept. The result leaves as a 64-bit writeback value with a valid strobe.

Two configuration inputs set the CPU byte order and the memory byte order, and a third requests byte-order reversal. Address translation is an identity mapping. The base register field of the instruction is not decoded, because the caller has already read that register and drives its value on `issue_base`. A bus-error response from memory stops the writeback and raises an error flag instead. The unit forwards its own newer results to a younger operation on the same destination. A pair of partial loads issued back to back therefore assembles a complete word, with no stall.

Top module: `unaligned_loadr_unit`

## Requirements
- R1: An operation is accepted only when `issue_valid` is 1 and `issue_instr[31:26]` equals 6'b100110. Any other opcode raises no `mem_req` and produces no writeback and no error.
- R2: The effective address `ea` is `issue_base` plus `issue_instr[15:0]` sign-extended to 64 bits. `mem_req` and `mem_addr` appear combinationally in the issue cycle. `mem_addr` is `{ea[63:3], ea[2:0] ^ {3{cfg_rev_endian}}}` when `cfg_big_mem` is 1, and `{ea[63:3], 3'b000}` when it is 0.
- R3: The byte index is `b = ea[1:0] ^ {2{cfg_big_cpu}}`. The word index is `w = ea[2] ^ cfg_big_cpu`. When `w` is 1 the source word is `mem_rdata[63:32]`, and when it is 0 the source word is `mem_rdata[31:0]`.
- R4: For each k from 0 to 3-b, result byte k is byte k+b of the source word. Result bytes 4-b to 3 keep the destination value.
- R5: When b = 0, so that all four bytes are loaded, result bits 63..32 are copies of result bit 31. No zero-extending form exists.
- R6: When b != 0 and parameter `PARTIAL_UPPER_SEXT` is 0, result bits 63..32 keep the destination's bits 63..32. When the parameter is 1, they are copies of the destination's bit 31.
- R7: `mem_rdata` and `mem_berr` are sampled in the cycle after the request. `wb_valid`, `wb_reg` (the rt field `issue_instr[20:16]`) and `wb_data` are registered and appear two cycles after the issue cycle. A new operation may issue in every cycle.
- R8: The destination value used for the merge is the newest value for that register. A result still in flight from the previous issue cycle has the highest priority. Next comes the result currently on `wb_valid`/`wb_data`. Only if neither applies is `issue_rt_val` used.
- R9: If `mem_berr` is 1 in an operation's data cycle, that operation raises `wb_err` for one cycle in place of `wb_valid`, and its data is never forwarded. `mem_berr` has no effect in a cycle with no operation awaiting data.
- R10: While `rst_n` is low at a clock edge, in-flight operations are discarded. `wb_valid` and `wb_err` are 0 after that edge, and the held writeback register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Operation present this cycle |
| issue_instr | input | 32 | Instruction word (opcode, rt field, offset) |
| issue_base | input | 64 | Base register value |
| issue_rt_val | input | 64 | Destination register value from the register file |
| cfg_big_cpu | input | 1 | CPU runs big-endian |
| cfg_big_mem | input | 1 | Memory is big-endian |
| cfg_rev_endian | input | 1 | Reverse byte order of the low address bits |
| mem_req | output | 1 | Read request strobe |
| mem_addr | output | 64 | Read address |
| mem_rdata | input | 64 | Read data, one cycle after the request |
| mem_berr | input | 1 | Bus error for the returning read |
| wb_valid | output | 1 | Writeback strobe |
| wb_err | output | 1 | Operation ended with a bus error |
| wb_reg | output | 5 | Destination register index |
| wb_data | output | 64 | Merged destination value |

## Verification
The bench walks every byte index and both word halves under each combination of byte-order inputs. A design that swapped the word select or shifted the wrong way would splice in the wrong memory bytes, and one that ignored the CPU byte order would fail the big-endian runs. Back-to-back and one-gap sequences to the same destination catch a missing or wrongly prioritised forward: the stale register-file value would reappear in the kept bytes. Bus errors followed by a same-register load show whether faulted data leaks through forwarding. A second instance built with the other partial-upper option, together with full loads that have bit 31 set, exposes upper-half handling that is missing, or that zero-extends.

// File: rtl/ulr_pkg.sv
// Shared constants for the unaligned load-right merge unit.
// Assumes a 64-bit datapath made of two 32-bit words, a 32-bit instruction word
// and a 5-bit register index.
package ulr_pkg;
    localparam int XLEN    = 64;
    localparam int HALF    = XLEN / 2;
    localparam int LANES   = HALF / 8;
    localparam int BIDX_W  = $clog2(LANES);
    localparam int DW_LSB  = $clog2(XLEN / 8);
    localparam int OFF_W   = 16;
    localparam int REG_W   = 5;
    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int RT_LSB  = OFF_W;
    localparam logic [OPC_W-1:0] OP_LOADR = 6'b100110;

    // State carried from the issue cycle into the data cycle
    typedef struct packed {
        logic [REG_W-1:0]  rt;
        logic [XLEN-1:0]   rt_val;
        logic [BIDX_W-1:0] bsel;
        logic              wsel;
    } ulr_stage_t;
endpackage

// File: rtl/ulr_addr_gen.sv
// Effective address and byte/word selector generation.
// Purely combinational. Translation is identity, so the request address is
// the effective address, aligned to a doubleword, with its low bits rewritten
// according to the memory byte-order configuration.
module ulr_addr_gen
    import ulr_pkg::*;
(
    input  logic [XLEN-1:0]   base_val,
    input  logic [OFF_W-1:0]  offset,
    input  logic              big_cpu,
    input  logic              big_mem,
    input  logic              rev_endian,
    output logic [XLEN-1:0]   req_addr,
    output logic [BIDX_W-1:0] byte_idx,
    output logic              word_idx
);
    logic [XLEN-1:0] eff;

    // Sum base and sign-extended offset, then derive the address and selectors
    always_comb begin
        eff      = base_val + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
        req_addr = {eff[XLEN-1:DW_LSB],
                    big_mem ? (eff[DW_LSB-1:0] ^ {DW_LSB{rev_endian}}) : {DW_LSB{1'b0}}};
        byte_idx = eff[BIDX_W-1:0] ^ {BIDX_W{big_cpu}};
        word_idx = eff[BIDX_W] ^ big_cpu;
    end
endmodule

// File: rtl/ulr_byte_merge.sv
// Right-hand byte merge.
// Picks one word of the returned doubleword and shifts it down by the byte
// index. It fills the low lanes of the destination with that word and keeps
// the lanes above them. The upper half is the sign of a full load; for a
// partial load it follows the SEXT_PARTIAL option.
module ulr_byte_merge
    import ulr_pkg::*;
#(
    parameter bit SEXT_PARTIAL = 1'b0
) (
    input  logic [XLEN-1:0]   rt_val,
    input  logic [XLEN-1:0]   mem_dw,
    input  logic [BIDX_W-1:0] byte_idx,
    input  logic              word_idx,
    output logic [XLEN-1:0]   merged
);
    logic [HALF-1:0] src_word;
    logic [HALF-1:0] shifted;
    logic [HALF-1:0] low_word;
    logic [HALF-1:0] partial_hi;
    logic [HALF-1:0] upper;

    // Select the addressed word and align its first wanted byte to lane 0
    always_comb begin
        src_word = word_idx ? mem_dw[XLEN-1:HALF] : mem_dw[HALF-1:0];
        shifted  = src_word >> {byte_idx, 3'b000};
    end

    // One lane per byte: memory while the lane lies below the loaded span's top
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign low_word[8*g +: 8] = ((g + int'(byte_idx)) < LANES) ? shifted[8*g +: 8]
                                                                   : rt_val[8*g +: 8];
    end

    // Upper half on a partial load, chosen at build time
    if (SEXT_PARTIAL) begin : g_part_sext
        assign partial_hi = {HALF{rt_val[HALF-1]}};
    end else begin : g_part_keep
        assign partial_hi = rt_val[XLEN-1:HALF];
    end

    // A full load (byte index zero) owns bit 31 and extends it upward
    always_comb begin
        upper  = (byte_idx == '0) ? {HALF{low_word[HALF-1]}} : partial_hi;
        merged = {upper, low_word};
    end
endmodule

// File: rtl/unaligned_loadr_unit.sv
// Unaligned load-right merge unit, top level.
// Issue cycle: decode the opcode, drive the read request, choose the freshest
// destination value and capture it. Data cycle: merge the returned doubleword.
// Writeback cycle: registered result or error flag.
// Assumes memory answers exactly one cycle after each request and that the
// register file is written at the end of a wb_valid cycle.
module unaligned_loadr_unit
    import ulr_pkg::*;
#(
    parameter bit PARTIAL_UPPER_SEXT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [INSN_W-1:0] issue_instr,
    input  logic [XLEN-1:0]   issue_base,
    input  logic [XLEN-1:0]   issue_rt_val,
    input  logic              cfg_big_cpu,
    input  logic              cfg_big_mem,
    input  logic              cfg_rev_endian,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_berr,
    output logic              wb_valid,
    output logic              wb_err,
    output logic [REG_W-1:0]  wb_reg,
    output logic [XLEN-1:0]   wb_data
);
    logic              hit;
    logic [REG_W-1:0]  issue_rt;
    logic [BIDX_W-1:0] new_bsel;
    logic              new_wsel;
    logic [XLEN-1:0]   rt_fwd;
    logic [XLEN-1:0]   merged;
    logic              s1_valid;
    logic              s1_good;
    ulr_stage_t        s1_q;

    ulr_addr_gen u_addr (
        .base_val  (issue_base),
        .offset    (issue_instr[OFF_W-1:0]),
        .big_cpu   (cfg_big_cpu),
        .big_mem   (cfg_big_mem),
        .rev_endian(cfg_rev_endian),
        .req_addr  (mem_addr),
        .byte_idx  (new_bsel),
        .word_idx  (new_wsel)
    );

    ulr_byte_merge #(.SEXT_PARTIAL(PARTIAL_UPPER_SEXT)) u_merge (
        .rt_val  (s1_q.rt_val),
        .mem_dw  (mem_rdata),
        .byte_idx(s1_q.bsel),
        .word_idx(s1_q.wsel),
        .merged  (merged)
    );

    // Decode: only the load-right opcode launches a request
    always_comb begin
        issue_rt = issue_instr[RT_LSB +: REG_W];
        hit      = issue_valid && (issue_instr[OPC_LSB +: OPC_W] == OP_LOADR);
        mem_req  = hit;
        s1_good  = s1_valid && !mem_berr;
    end

    // Forward the newest pending value: data-cycle result beats the held writeback
    always_comb begin
        rt_fwd = issue_rt_val;
        if (wb_valid && (wb_reg == issue_rt)) rt_fwd = wb_data;
        if (s1_good && (s1_q.rt == issue_rt)) rt_fwd = merged;
    end

    // Issue-to-data stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_q     <= '0;
        end else begin
            s1_valid <= hit;
            if (hit) s1_q <= '{rt: issue_rt, rt_val: rt_fwd, bsel: new_bsel, wsel: new_wsel};
        end
    end

    // Writeback register, also the source of the one-gap forward
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_err   <= 1'b0;
            wb_reg   <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= s1_good;
            wb_err   <= s1_valid && mem_berr;
            if (s1_good) begin
                wb_reg  <= s1_q.rt;
                wb_data <= merged;
            end
        end
    end

    // Writeback arrives exactly two cycles after its request
    AST_WB_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(mem_req, 2)); // R7

    // An error flag needs a waiting operation and a bus error in the data cycle
    AST_ERR_FROM_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |-> ($past(mem_berr) && $past(s1_valid))); // R9

    // Error and writeback never coincide
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && wb_err)); // R9

    // A full four-byte load sign-extends its new bit 31
    AST_FULL_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(s1_valid && (s1_q.bsel == '0)))
            |-> (wb_data[XLEN-1:HALF] == {HALF{wb_data[HALF-1]}})); // R5

    // A partial load keeps or replicates the old upper half as configured
    AST_PARTIAL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(s1_valid && (s1_q.bsel != '0)))
            |-> (wb_data[XLEN-1:HALF] == (PARTIAL_UPPER_SEXT ? {HALF{$past(s1_q.rt_val[HALF-1])}}
                                                              : $past(s1_q.rt_val[XLEN-1:HALF])))); // R6
endmodule

// File: tb/sim_unaligned_loadr_unit.sv
// Bench: behavioural reference model compared on every clock. Two instances,
// one per partial-upper option, share stimulus and have their own register files.
module sim_unaligned_loadr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        issue_valid, big_cpu, big_mem, rev, mem_berr;
    logic [31:0] issue_instr;
    logic [63:0] issue_base, mem_rdata;
    logic [63:0] rt_val   [2];
    logic        mem_req  [2];
    logic [63:0] mem_addr [2];
    logic        wb_valid [2];
    logic        wb_err   [2];
    logic [4:0]  wb_reg   [2];
    logic [63:0] wb_data  [2];

    unaligned_loadr_unit #(.PARTIAL_UPPER_SEXT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .issue_base(issue_base), .issue_rt_val(rt_val[0]), .cfg_big_cpu(big_cpu),
        .cfg_big_mem(big_mem), .cfg_rev_endian(rev), .mem_req(mem_req[0]),
        .mem_addr(mem_addr[0]), .mem_rdata(mem_rdata), .mem_berr(mem_berr),
        .wb_valid(wb_valid[0]), .wb_err(wb_err[0]), .wb_reg(wb_reg[0]), .wb_data(wb_data[0]));

    unaligned_loadr_unit #(.PARTIAL_UPPER_SEXT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .issue_base(issue_base), .issue_rt_val(rt_val[1]), .cfg_big_cpu(big_cpu),
        .cfg_big_mem(big_mem), .cfg_rev_endian(rev), .mem_req(mem_req[1]),
        .mem_addr(mem_addr[1]), .mem_rdata(mem_rdata), .mem_berr(mem_berr),
        .wb_valid(wb_valid[1]), .wb_err(wb_err[1]), .wb_reg(wb_reg[1]), .wb_data(wb_data[1]));

    localparam logic [5:0] OPC = 6'b100110;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [63:0] env    [2][32];
    logic [63:0] latest [2][32];
    bit          p_v, p_berr, p_w, e_v, e_err, e_full, rst_prev;
    logic [63:0] p_addr;
    logic [4:0]  p_rt, e_rt;
    int          p_b;
    logic [63:0] e_data [2];

    function automatic logic [63:0] mem_fn(input logic [63:0] a);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[10:3] * 8'd7) ^ (8'h30 + 8'(i)) ^ a[18:11];
        return r;
    endfunction

    function automatic logic [63:0] ref_merge(input logic [63:0] rt, input logic [63:0] dw,
                                              input int b, input bit w, input bit sext);
        logic [31:0] mw, lo, hi;
        mw = w ? dw[63:32] : dw[31:0];
        lo = rt[31:0];
        for (int k = 0; k < 4 - b; k++) lo[8*k +: 8] = mw[8*(k+b) +: 8];
        if (b == 0)    hi = {32{lo[31]}};
        else if (sext) hi = {32{rt[31]}};
        else           hi = rt[63:32];
        return {hi, lo};
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt, input logic [15:0] off);
        return {op, 5'd9, rt, off};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit rst, input bit v, input logic [31:0] instr, input logic [63:0] base,
                        input bit bc, input bit bm, input bit rv, input bit berr);
        bit dec, w, n_v, n_err;
        logic [63:0] ea, addr, res;
        logic [4:0] rt;
        int b;
        @(negedge clk);
        rt = instr[20:16];
        rst_n = !rst; issue_valid = v; issue_instr = instr; issue_base = base;
        big_cpu = bc; big_mem = bm; rev = rv;
        for (int k = 0; k < 2; k++) rt_val[k] = env[k][rt];
        mem_rdata = p_v ? mem_fn(p_addr) : 64'hC0FF_EE00_1234_5678;
        mem_berr = p_berr;   // R9: also driven with no operation waiting
        #1;
        for (int k = 0; k < 2; k++) begin
            chk(rst_prev ? "R10" : "R7", "wb_valid", 64'(wb_valid[k]), 64'(e_v));
            chk("R9", "wb_err", 64'(wb_err[k]), 64'(e_err));
            if (e_v && wb_valid[k] === 1'b1) begin
                chk("R7", "wb_reg", 64'(wb_reg[k]), 64'(e_rt));
                chk("R4 R8", "wb_data low", 64'(wb_data[k][31:0]), 64'(e_data[k][31:0]));
                chk(e_full ? "R5" : "R6", "wb_data high", 64'(wb_data[k][63:32]), 64'(e_data[k][63:32]));
            end
        end
        dec  = v && (instr[31:26] == OPC);
        ea   = base + {{48{instr[15]}}, instr[15:0]};
        addr = bm ? {ea[63:3], ea[2:0] ^ {3{rv}}} : {ea[63:3], 3'b000};
        b    = int'(ea[1:0] ^ {2{bc}});   // R3 byte index
        w    = ea[2] ^ bc;                // R3 word index
        for (int k = 0; k < 2; k++) begin
            chk("R1", "mem_req", 64'(mem_req[k]), 64'(dec));
            if (dec) chk("R2", "mem_addr", mem_addr[k], addr);
        end
        for (int k = 0; k < 2; k++) if (wb_valid[k] === 1'b1) env[k][wb_reg[k]] = wb_data[k];
        n_v = 0; n_err = 0;
        if (p_v && !rst) begin
            if (p_berr) n_err = 1;
            else begin
                n_v = 1;
                for (int k = 0; k < 2; k++) begin
                    res = ref_merge(latest[k][p_rt], mem_fn(p_addr), p_b, p_w, k == 1);
                    latest[k][p_rt] = res;
                    e_data[k] = res;
                end
            end
            e_rt = p_rt; e_full = (p_b == 0);
        end
        e_v = n_v; e_err = n_err;
        if (rst) begin
            for (int k = 0; k < 2; k++) for (int i = 0; i < 32; i++) latest[k][i] = env[k][i];
            p_v = 0;
        end else begin
            p_v = dec; p_rt = rt; p_addr = addr; p_b = b; p_w = w;
        end
        p_berr = berr;
        rst_prev = rst;
    endtask

    task automatic idle();
        step(0, 0, 32'h0, 64'h0, 0, 1, 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 32; i++) begin
                env[k][i]    = {8'(i), 24'hA1B2C3, 32'h8D7E_6F50 ^ 32'(i)};
                latest[k][i] = env[k][i];
            end
        issue_valid = 0; issue_instr = 0; issue_base = 0; big_cpu = 0; big_mem = 1; rev = 0;
        mem_rdata = 0; mem_berr = 0; rt_val[0] = 0; rt_val[1] = 0;
        p_v = 0; p_berr = 0; e_v = 0; e_err = 0; e_full = 0; rst_prev = 1; e_rt = 0;
        @(posedge clk);
        // R10: reset state
        repeat (3) step(1, 0, 32'h0, 64'h0, 0, 1, 0, 0);
        // R3 R4 R5 R6: every byte and word, little and big CPU order
        for (int bc = 0; bc < 2; bc++)
            for (int off = 0; off < 8; off++) begin
                step(0, 1, mk(OPC, 5'd1, 16'(off)), 64'h1000, bit'(bc), 1, 0, 0);
                idle(); idle();
            end
        // R2: reversed low bits, little-endian memory, negative offset
        for (int off = 0; off < 8; off++) begin
            step(0, 1, mk(OPC, 5'd5, 16'(off)), 64'h2345_6780, 0, 1, 1, 0);
            step(0, 1, mk(OPC, 5'd6, 16'(off)), 64'h2345_6780, 1, 0, 1, 0);
        end
        step(0, 1, mk(OPC, 5'd7, 16'hFFF9), 64'h2000, 0, 1, 0, 0);
        idle(); idle();
        // R1: other opcodes ignored
        step(0, 1, mk(6'b100010, 5'd1, 16'h3), 64'h1000, 0, 1, 0, 0);
        step(0, 1, mk(6'b100011, 5'd1, 16'h2), 64'h1000, 0, 1, 0, 0);
        step(0, 0, mk(OPC, 5'd1, 16'h1), 64'h1000, 0, 1, 0, 0);
        idle(); idle();
        // R8: back to back and one-gap on the same destination
        step(0, 1, mk(OPC, 5'd2, 16'h1), 64'h3000, 0, 1, 0, 0);
        step(0, 1, mk(OPC, 5'd2, 16'h6), 64'h3000, 0, 1, 0, 0);
        step(0, 1, mk(OPC, 5'd2, 16'h3), 64'h3008, 0, 1, 0, 0);
        step(0, 1, mk(OPC, 5'd3, 16'h2), 64'h4000, 0, 1, 0, 0);
        idle();
        step(0, 1, mk(OPC, 5'd3, 16'h5), 64'h4010, 0, 1, 0, 0);
        idle(); idle(); idle();
        // R9: bus error then same-register load; error data not forwarded
        step(0, 1, mk(OPC, 5'd4, 16'h1), 64'h5000, 0, 1, 0, 1);
        step(0, 1, mk(OPC, 5'd4, 16'h2), 64'h5000, 0, 1, 0, 0);
        step(0, 0, 32'h0, 64'h0, 0, 1, 0, 1);
        idle(); idle();
        // R10: reset with operations in flight
        step(0, 1, mk(OPC, 5'd1, 16'h1), 64'h6000, 0, 1, 0, 0);
        step(0, 1, mk(OPC, 5'd1, 16'h2), 64'h6000, 0, 1, 0, 0);
        step(1, 0, 32'h0, 64'h0, 0, 1, 0, 0);
        idle(); idle();
        // Random mix of all of the above
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] op;
            op = ($urandom % 8 == 0) ? 6'b100011 : OPC;
            step(0, ($urandom % 4) != 0, mk(op, 5'(1 + $urandom % 4), 16'($urandom)),
                 {32'($urandom), 32'($urandom)}, bit'($urandom % 2), bit'($urandom % 2),
                 bit'($urandom % 2), ($urandom % 8) == 0);
        end
        idle(); idle(); idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule